// File: doc/BRIEF.md
# Header-Driven SPI Transaction Engine

This block is the transaction core of a SPI master. It owns a 512-byte byte buffer that software fills through a simple byte port. The first two bytes form a big-endian command header: the operation and the byte count. Transmit payload follows the header. Software then writes a 16-bit command word. The word names the slave and the timing profile and asks for either an immediate start or a start on an external trigger. The engine reads the header from the buffer, runs the operation and shifts payload bytes MSB first, one bit slot per clock. Received bytes are written back over the buffer from offset zero. When the operation ends, busy drops and a one-cycle done pulse goes out.

The supported operations are a timed sleep, full duplex, write-only, read-only and raising an interrupt pulse. Read-only and write-only transfers can use two data lanes when the header asks for it and the selected profile allows that direction. Commands also include halt and flush, which abort a running operation. Bad command codes, bad operations and over-long counts raise an error flag and leave the engine idle. Clock waveform generation and chip-select pin control sit outside the block. The engine marks each bit slot with a strobe and publishes the latched slave and profile numbers.

Top module: `hdr_spi_engine`

## Requirements
- R1: After reset, busy, done, interrupt, error flag and bit-slot strobe are all low.
- R2: The header is buffer byte 0 (bits 15:8) and byte 1 (bits 7:0). Bits 15:13 are the operation (0 sleep, 1 full duplex, 2 write, 3 read, 4 interrupt) and bits 9:0 are the byte count. Transmit bytes come from offset 2 upward, MSB first on lane 0, one bit per strobe. A read-only transfer drives lane 0 low.
- R3: For read and full duplex, received byte k goes to buffer offset k. A write-only transfer leaves the buffer unchanged, header included.
- R4: When header bit 11 is set and the profile's enable bit for that direction is set, a read or write moves two bits per strobe, the earlier bit on lane 1, so a byte takes 4 strobes. The enables are the read-dual vector for read and the write-dual vector for write. Otherwise a byte takes 8 strobes. Full duplex is always single lane.
- R5: A sleep of count N produces no strobes, and its done pulse comes exactly N cycles later than that of a sleep of count 0.
- R6: The interrupt operation produces no strobes and gives a one-cycle interrupt pulse in the same cycle as done.
- R7: Command bits 3:0 are 0 no-op, 1 start now, 2 start on trigger, 3 halt, 4 flush. A no-op changes nothing. Start on trigger holds busy high with no strobes until ext_trig is seen, and then runs the operation.
- R8: Halt while busy clears busy on the next cycle, stops the strobes and gives no done pulse.
- R9: Any of these sets the error flag and leaves the engine idle with no strobes: a command code above 4, an operation above 4, a read count above 512, or a write or full-duplex count above 510. A read of 512 and a write of 510 are accepted. Flush clears the flag.
- R10: Done is a single-cycle pulse that coincides with the first cycle in which busy is low.
- R11: While busy, the slave and profile outputs hold command bits 15:12 and 11:8 of the starting command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software buffer write enable |
| sw_addr | input | 9 | Software buffer byte address |
| sw_wdata | input | 8 | Software buffer write data |
| sw_rdata | output | 8 | Buffer byte at sw_addr |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command: code 3:0, profile 11:8, slave 15:12 |
| ext_trig | input | 1 | External start trigger |
| prof_dual_rd | input | 16 | Per-profile dual-lane read enable |
| prof_dual_wr | input | 16 | Per-profile dual-lane write enable |
| busy_o | output | 1 | Command executing |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Interrupt operation pulse |
| inval_o | output | 1 | Invalid-control error flag |
| ss_o | output | 4 | Latched slave number |
| prof_o | output | 4 | Latched profile number |
| sck_slot_o | output | 1 | Bit-slot strobe |
| mosi_o | output | 2 | Outgoing data lanes |
| miso_i | input | 2 | Incoming data lanes |

## Verification
Transfers are run in each direction with distinct payloads and a slave model that returns a known byte ramp. This separates the transmit path, which is seen on the lanes, from the receive path, which is read back from the buffer. The same read and write operations are tried with dual enabled only in the header, only in the profile, and in both. Only the last case may halve the strobe count. Count limits are probed on both sides of each bound. Sleep lengths are compared against each other to fix the cycle cost. Halt, trigger arming and illegal codes are each driven mid-operation or while idle, to show which of them stop the strobes and which give done.

// File: rtl/hse_pkg.sv
package hse_pkg;
    localparam logic [2:0] OP_SLEEP = 3'd0;
    localparam logic [2:0] OP_RW    = 3'd1;
    localparam logic [2:0] OP_WR    = 3'd2;
    localparam logic [2:0] OP_RD    = 3'd3;
    localparam logic [2:0] OP_IRQ   = 3'd4;

    localparam logic [3:0] CMD_NOP   = 4'd0;
    localparam logic [3:0] CMD_GO    = 4'd1;
    localparam logic [3:0] CMD_ARM   = 4'd2;
    localparam logic [3:0] CMD_HALT  = 4'd3;
    localparam logic [3:0] CMD_FLUSH = 4'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_WAIT
    } st_e;
endpackage

// File: rtl/hse_buffer.sv
module hse_buffer #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata,
    output logic [15:0]   hdr_o
);
    logic [7:0] mem_q [DEPTH];

    // engine write wins over a software write in the same cycle
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem_q[eng_waddr] <= eng_wdata;
        end else if (sw_we) begin
            mem_q[sw_addr] <= sw_wdata;
        end
    end

    assign sw_rdata  = mem_q[sw_addr];
    assign eng_rdata = mem_q[eng_raddr];
    assign hdr_o     = {mem_q[0], mem_q[1]};
endmodule

// File: rtl/hse_hdr_decode.sv
module hse_hdr_decode
    import hse_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int HDR_BYTES = 2,
    parameter int NPROF     = 16,
    localparam int CW = $clog2(BUF_BYTES) + 1,
    localparam int PW = $clog2(NPROF)
) (
    input  logic [15:0]      hdr,
    input  logic [PW-1:0]    prof,
    input  logic [NPROF-1:0] dual_rd,
    input  logic [NPROF-1:0] dual_wr,
    output logic [2:0]       op,
    output logic [CW-1:0]    count,
    output logic             dual,
    output logic             ok
);
    localparam logic [CW-1:0] RD_MAX = CW'(BUF_BYTES);
    localparam logic [CW-1:0] WR_MAX = CW'(BUF_BYTES - HDR_BYTES);

    logic multibit;

    always_comb begin
        op       = hdr[15:13];
        multibit = hdr[11];
        count    = hdr[CW-1:0];
        dual     = multibit && (((op == OP_RD) && dual_rd[prof]) ||
                                ((op == OP_WR) && dual_wr[prof]));
        case (op)
            OP_SLEEP, OP_IRQ: ok = 1'b1;
            OP_RD:            ok = (count <= RD_MAX);
            OP_RW, OP_WR:     ok = (count <= WR_MAX);
            default:          ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/hse_shifter.sv
module hse_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic       dual,
    input  logic [7:0] tx_byte,
    input  logic [1:0] miso,
    output logic [1:0] mosi,
    output logic       slot,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic       active;
        logic       dual;
        logic [3:0] left;
        logic [7:0] sh;
        logic [7:0] rx;
        logic       done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort) begin
            d.active = 1'b0;
        end else if (q.active) begin
            if (q.dual) begin
                d.sh = {q.sh[5:0], 2'b00};
                d.rx = {q.rx[5:0], miso};
            end else begin
                d.sh = {q.sh[6:0], 1'b0};
                d.rx = {q.rx[6:0], miso[0]};
            end
            d.left = q.left - 4'd1;
            if (q.left == 4'd1) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end else if (start) begin
            d.active = 1'b1;
            d.dual   = dual;
            d.sh     = tx_byte;
            d.rx     = 8'h00;
            d.left   = dual ? 4'd4 : 4'd8;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign slot      = q.active;
    assign mosi      = q.active ? (q.dual ? q.sh[7:6] : {1'b0, q.sh[7]}) : 2'b00;
    assign byte_done = q.done;
    assign rx_byte   = q.rx;

    assert_byte_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.active);
    assert_slot_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.left != 4'd0) && (q.left <= (q.dual ? 4'd4 : 4'd8)));
endmodule

// File: rtl/hdr_spi_engine.sv
module hdr_spi_engine
    import hse_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int HDR_BYTES = 2,
    parameter int NPROF     = 16,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int CW = AW + 1,
    localparam int PW = $clog2(NPROF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [AW-1:0]    sw_addr,
    input  logic [7:0]       sw_wdata,
    output logic [7:0]       sw_rdata,
    input  logic             cmd_valid,
    input  logic [15:0]      cmd_word,
    input  logic             ext_trig,
    input  logic [NPROF-1:0] prof_dual_rd,
    input  logic [NPROF-1:0] prof_dual_wr,
    output logic             busy_o,
    output logic             done_o,
    output logic             irq_o,
    output logic             inval_o,
    output logic [3:0]       ss_o,
    output logic [3:0]       prof_o,
    output logic             sck_slot_o,
    output logic [1:0]       mosi_o,
    input  logic [1:0]       miso_i
);
    typedef struct packed {
        st_e           st;
        logic [2:0]    op;
        logic [CW-1:0] cnt;
        logic [CW-1:0] idx;
        logic          dual;
        logic [3:0]    ss;
        logic [3:0]    prof;
        logic          done;
        logic          irq;
        logic          inval;
    } eng_t;

    eng_t q, d;

    logic          sh_start, sh_abort, sh_done;
    logic [7:0]    sh_rx;
    logic          eng_we;
    logic [AW-1:0] eng_raddr;
    logic [7:0]    eng_rdata;
    logic [15:0]   hdr;
    logic [3:0]    dec_prof;
    logic [2:0]    dec_op;
    logic [CW-1:0] dec_cnt;
    logic          dec_dual, dec_ok;
    logic [3:0]    code;

    hse_buffer #(.DEPTH(BUF_BYTES)) u_buf (
        .clk       (clk),
        .sw_we     (sw_we),
        .sw_addr   (sw_addr),
        .sw_wdata  (sw_wdata),
        .sw_rdata  (sw_rdata),
        .eng_we    (eng_we),
        .eng_waddr (q.idx[AW-1:0]),
        .eng_wdata (sh_rx),
        .eng_raddr (eng_raddr),
        .eng_rdata (eng_rdata),
        .hdr_o     (hdr)
    );

    hse_hdr_decode #(
        .BUF_BYTES (BUF_BYTES),
        .HDR_BYTES (HDR_BYTES),
        .NPROF     (NPROF)
    ) u_dec (
        .hdr     (hdr),
        .prof    (dec_prof[PW-1:0]),
        .dual_rd (prof_dual_rd),
        .dual_wr (prof_dual_wr),
        .op      (dec_op),
        .count   (dec_cnt),
        .dual    (dec_dual),
        .ok      (dec_ok)
    );

    hse_shifter u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .abort     (sh_abort),
        .dual      (q.dual),
        .tx_byte   ((q.op == OP_RD) ? 8'h00 : eng_rdata),
        .miso      (miso_i),
        .mosi      (mosi_o),
        .slot      (sck_slot_o),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    assign code      = cmd_word[3:0];
    assign dec_prof  = (q.st == ST_ARMED) ? q.prof : cmd_word[11:8];
    // the next byte's address while waiting, the first byte's otherwise
    assign eng_raddr = (q.st == ST_WAIT) ? AW'(q.idx + CW'(HDR_BYTES + 1))
                                         : AW'(q.idx + CW'(HDR_BYTES));

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.irq    = 1'b0;
        sh_start = 1'b0;
        sh_abort = 1'b0;
        eng_we   = 1'b0;

        case (q.st)
            ST_ARMED: begin
                if (ext_trig) begin
                    if (dec_ok) begin
                        d.op   = dec_op;
                        d.cnt  = dec_cnt;
                        d.dual = dec_dual;
                        d.idx  = '0;
                        d.st   = ST_RUN;
                    end else begin
                        d.inval = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
            end
            ST_RUN: begin
                case (q.op)
                    OP_SLEEP: begin
                        if (q.idx == q.cnt) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.idx = q.idx + CW'(1);
                        end
                    end
                    OP_IRQ: begin
                        d.irq  = 1'b1;
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                    default: begin
                        if (q.cnt == '0) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            sh_start = 1'b1;
                            d.st     = ST_WAIT;
                        end
                    end
                endcase
            end
            ST_WAIT: begin
                if (sh_done) begin
                    eng_we = (q.op != OP_WR);
                    d.idx  = q.idx + CW'(1);
                    if (q.idx + CW'(1) == q.cnt) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        sh_start = 1'b1;
                    end
                end
            end
            default: ;
        endcase

        if (cmd_valid) begin
            case (code)
                CMD_NOP: ;
                CMD_GO: begin
                    if (q.st == ST_IDLE) begin
                        d.ss   = cmd_word[15:12];
                        d.prof = cmd_word[11:8];
                        if (dec_ok) begin
                            d.op   = dec_op;
                            d.cnt  = dec_cnt;
                            d.dual = dec_dual;
                            d.idx  = '0;
                            d.st   = ST_RUN;
                        end else begin
                            d.inval = 1'b1;
                        end
                    end
                end
                CMD_ARM: begin
                    if (q.st == ST_IDLE) begin
                        d.ss   = cmd_word[15:12];
                        d.prof = cmd_word[11:8];
                        d.st   = ST_ARMED;
                    end
                end
                CMD_HALT, CMD_FLUSH: begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b0;
                    d.irq    = 1'b0;
                    sh_start = 1'b0;
                    sh_abort = 1'b1;
                    eng_we   = 1'b0;
                    if (code == CMD_FLUSH) begin
                        d.inval = 1'b0;
                    end
                end
                default: begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b0;
                    d.irq    = 1'b0;
                    sh_start = 1'b0;
                    sh_abort = 1'b1;
                    eng_we   = 1'b0;
                    d.inval  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.st != ST_IDLE);
    assign done_o  = q.done;
    assign irq_o   = q.irq;
    assign inval_o = q.inval;
    assign ss_o    = q.ss;
    assign prof_o  = q.prof;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_irq_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);
    assert_slot_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_slot_o |-> busy_o);
    assert_halt_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (code == CMD_HALT)) |=> (!busy_o && !done_o && !sck_slot_o));
    assert_inval_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inval_o) |-> (!busy_o && !sck_slot_o));
    assert_armed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ARMED) |-> !sck_slot_o);
endmodule

// File: tb/hdr_spi_engine_tb.sv
module hdr_spi_engine_tb;
    localparam int AW = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic [7:0]  sw_wdata = '0;
    logic [7:0]  sw_rdata;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        ext_trig = 1'b0;
    logic [15:0] prof_dual_rd = 16'h0004;
    logic [15:0] prof_dual_wr = 16'h0008;
    logic        busy_o, done_o, irq_o, inval_o, sck_slot_o;
    logic [3:0]  ss_o, prof_o;
    logic [1:0]  mosi_o, miso_i;

    always #4 clk = ~clk;

    hdr_spi_engine u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .ext_trig(ext_trig), .prof_dual_rd(prof_dual_rd),
        .prof_dual_wr(prof_dual_wr), .busy_o(busy_o), .done_o(done_o),
        .irq_o(irq_o), .inval_o(inval_o), .ss_o(ss_o), .prof_o(prof_o),
        .sck_slot_o(sck_slot_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    // slave model: returns a byte ramp (seed, seed+0x13, ...) and records lanes
    logic [7:0] slave_sh = '0, slave_next = '0, mon_sh = '0;
    logic [7:0] mon_bytes [0:15];
    int mon_n = 0, mbits = 0, slot_cnt = 0;
    bit mdual = 1'b0;

    assign miso_i = mdual ? slave_sh[7:6] : {1'b0, slave_sh[7]};

    always @(posedge clk) begin
        if (sck_slot_o) begin
            slot_cnt <= slot_cnt + 1;
            if (mdual) begin
                mon_sh   <= {mon_sh[5:0], mosi_o};
                slave_sh <= {slave_sh[5:0], 2'b00};
            end else begin
                mon_sh   <= {mon_sh[6:0], mosi_o[0]};
                slave_sh <= {slave_sh[6:0], 1'b0};
            end
            if (mbits + (mdual ? 2 : 1) == 8) begin
                if (mon_n < 16)
                    mon_bytes[mon_n] <= mdual ? {mon_sh[5:0], mosi_o} : {mon_sh[6:0], mosi_o[0]};
                mon_n      <= mon_n + 1;
                mbits      <= 0;
                slave_sh   <= slave_next;
                slave_next <= slave_next + 8'h13;
            end else begin
                mbits <= mbits + (mdual ? 2 : 1);
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic sw_write(input int a, input logic [7:0] v);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = AW'(a); sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input int a, output logic [7:0] v);
        @(negedge clk);
        sw_addr = AW'(a);
        #1 v = sw_rdata;
    endtask

    function automatic logic [15:0] mk_hdr(input logic [2:0] op, input logic mb, input int cnt);
        return {op, 1'b0, mb, 1'b0, 10'(cnt)};
    endfunction

    task automatic load_hdr(input logic [15:0] h);
        sw_write(0, h[15:8]);
        sw_write(1, h[7:0]);
    endtask

    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic prep(input logic [7:0] seed, input bit dl);
        @(negedge clk);
        slave_sh = seed; slave_next = seed + 8'h13; mon_sh = '0;
        mbits = 0; mon_n = 0; slot_cnt = 0; mdual = dl;
    endtask

    task automatic wait_done(input int lim, output int cyc, output bit seen, output bit irq_seen);
        cyc = 0; seen = 1'b0; irq_seen = 1'b0;
        while (!done_o && cyc < lim) begin
            @(negedge clk);
            cyc++;
        end
        seen = done_o;
        irq_seen = irq_o;
    endtask

    typedef struct packed {
        logic [2:0] op;
        logic       mb;
        logic [9:0] cnt;
        logic [3:0] prof;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd1, 1'b0, 10'd4, 4'd0, 8'h11},
        '{3'd2, 1'b0, 10'd3, 4'd1, 8'h22},
        '{3'd3, 1'b0, 10'd5, 4'd0, 8'h33},
        '{3'd3, 1'b1, 10'd4, 4'd2, 8'h44},
        '{3'd2, 1'b1, 10'd6, 4'd3, 8'h55},
        '{3'd3, 1'b1, 10'd3, 4'd0, 8'h66},
        '{3'd1, 1'b1, 10'd2, 4'd2, 8'h77},
        '{3'd2, 1'b0, 10'd1, 4'd5, 8'h88}
    };

    initial begin
        int cyc, cyc0, s0;
        bit seen, irqs;
        logic [7:0] b;
        logic [15:0] h;

        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !irq_o && !inval_o && !sck_slot_o, "R1 reset state",
            {busy_o, done_o, irq_o, inval_o, sck_slot_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table walk
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            bit dl;
            int nb;
            v  = VECS[i];
            dl = v.mb && (((v.op == 3'd3) && v.prof == 4'd2) || ((v.op == 3'd2) && v.prof == 4'd3));
            nb = int'(v.cnt);
            h  = mk_hdr(v.op, v.mb, nb);
            load_hdr(h);
            for (int k = 0; k < nb; k++) sw_write(2 + k, 8'h5A ^ 8'(k * 7 + i));
            prep(v.seed, dl);
            issue({4'(i), v.prof, 4'h0, 4'd1});
            chk(busy_o && ss_o == 4'(i) && prof_o == v.prof, "R11 slave/profile latched",
                {busy_o, ss_o, prof_o}, {1'b1, 4'(i), v.prof});
            wait_done(500, cyc, seen, irqs);
            chk(seen, "R10 done seen", seen, 1);
            @(negedge clk);
            chk(!done_o, "R10 done one cycle", done_o, 0);
            chk(slot_cnt == nb * (dl ? 4 : 8), "R4 strobe count", slot_cnt, nb * (dl ? 4 : 8));
            for (int k = 0; k < nb; k++) begin
                logic [7:0] exp_tx;
                exp_tx = (v.op == 3'd3) ? 8'h00 : (8'h5A ^ 8'(k * 7 + i));
                chk(mon_bytes[k] == exp_tx, "R2 lane data", mon_bytes[k], exp_tx);
            end
            if (v.op == 3'd2) begin
                sw_read(0, b); chk(b == h[15:8], "R3 write keeps header hi", b, h[15:8]);
                sw_read(1, b); chk(b == h[7:0], "R3 write keeps header lo", b, h[7:0]);
            end else begin
                for (int k = 0; k < nb; k++) begin
                    logic [7:0] exp_rx;
                    exp_rx = v.seed + 8'(k * 8'h13);
                    sw_read(k, b);
                    chk(b == exp_rx, "R3 received byte", b, exp_rx);
                end
            end
        end

        // R5 sleep timing
        load_hdr(mk_hdr(3'd0, 1'b0, 0));
        prep(8'h00, 1'b0);
        issue(16'h0001);
        wait_done(100, cyc0, seen, irqs);
        load_hdr(mk_hdr(3'd0, 1'b0, 7));
        prep(8'h00, 1'b0);
        issue(16'h0001);
        wait_done(100, cyc, seen, irqs);
        chk(seen && (cyc - cyc0) == 7, "R5 sleep length", cyc - cyc0, 7);
        chk(slot_cnt == 0, "R5 sleep no strobes", slot_cnt, 0);

        // R6 interrupt op
        load_hdr(mk_hdr(3'd4, 1'b0, 0));
        prep(8'h00, 1'b0);
        issue(16'h0001);
        wait_done(100, cyc, seen, irqs);
        chk(seen && irqs, "R6 irq with done", {seen, irqs}, 3);
        chk(slot_cnt == 0, "R6 no strobes", slot_cnt, 0);
        @(negedge clk);
        chk(!irq_o, "R6 irq one cycle", irq_o, 0);

        // R7 no-op and trigger arming
        issue(16'h0000);
        chk(!busy_o && !inval_o, "R7 no-op idle", {busy_o, inval_o}, 0);
        load_hdr(mk_hdr(3'd2, 1'b0, 2));
        prep(8'h00, 1'b0);
        issue(16'h2102);
        repeat (6) @(negedge clk);
        chk(busy_o && slot_cnt == 0 && !done_o, "R7 armed waits", {busy_o, 8'(slot_cnt)}, 9'h100);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        wait_done(200, cyc, seen, irqs);
        chk(seen && slot_cnt == 16, "R7 triggered run", slot_cnt, 16);

        // R8 halt mid-transfer
        load_hdr(mk_hdr(3'd3, 1'b0, 8));
        prep(8'h00, 1'b0);
        issue(16'h0001);
        repeat (20) @(negedge clk);
        issue(16'h0003);
        chk(!busy_o, "R8 halt clears busy", busy_o, 0);
        s0 = slot_cnt;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        chk(!seen && slot_cnt == s0, "R8 no done or strobes after halt", slot_cnt, s0);

        // R9 illegal code, flush, illegal op, limits
        issue(16'h000B);
        chk(inval_o && !busy_o, "R9 bad command code", inval_o, 1);
        issue(16'h0004);
        chk(!inval_o, "R9 flush clears", inval_o, 0);
        load_hdr(mk_hdr(3'd5, 1'b0, 1));
        prep(8'h00, 1'b0);
        issue(16'h0001);
        repeat (3) @(negedge clk);
        chk(inval_o && !busy_o && slot_cnt == 0, "R9 bad operation", {inval_o, busy_o}, 2);
        issue(16'h0004);
        load_hdr(mk_hdr(3'd2, 1'b0, 511));
        issue(16'h0001);
        repeat (3) @(negedge clk);
        chk(inval_o && !busy_o && slot_cnt == 0, "R9 write 511 rejected", {inval_o, busy_o}, 2);
        issue(16'h0004);
        load_hdr(mk_hdr(3'd3, 1'b0, 513));
        issue(16'h0001);
        chk(inval_o && !busy_o, "R9 read 513 rejected", {inval_o, busy_o}, 2);
        issue(16'h0004);
        load_hdr(mk_hdr(3'd1, 1'b0, 510));
        prep(8'h00, 1'b0);
        issue(16'h0001);
        wait_done(8000, cyc, seen, irqs);
        chk(seen && !inval_o && slot_cnt == 4080, "R9 duplex 510 accepted", slot_cnt, 4080);
        load_hdr(mk_hdr(3'd3, 1'b0, 512));
        prep(8'h07, 1'b0);
        issue(16'h0001);
        wait_done(8000, cyc, seen, irqs);
        chk(seen && !inval_o && slot_cnt == 4096, "R9 read 512 accepted", slot_cnt, 4096);
        sw_read(511, b);
        chk(b == 8'(8'h07 + 511 * 8'h13), "R3 last of 512 bytes", b, 8'(8'h07 + 511 * 8'h13));
        load_hdr(mk_hdr(3'd0, 1'b0, 50));
        issue(16'h0001);
        repeat (5) @(negedge clk);
        issue(16'h000F);
        chk(inval_o && !busy_o, "R9 bad code aborts busy", {inval_o, busy_o}, 2);

        summary();
    end
endmodule